// File: doc/BRIEF.md
# Packed SIMD Subtract Unit

This block is the execution stage for two packed-subtract instructions of a 32-bit processor. Each cycle it may accept one instruction word together with the two operand values that the register file has already read. It decodes the word and subtracts the second operand from the first, either as four independent 8-bit lanes or as two independent 16-bit lanes. One clock later it returns the destination register index, the packed difference and a write enable, with a valid strobe.

The unit also keeps the processor's overflow and sticky-overflow status bits. The overflow bit is rewritten by every instruction that executes. The sticky bit only accumulates. The carry bit passes through untouched. The source register indices are decoded combinationally so that the surrounding register file can look up the operands in the same cycle.

Top module: `psub_unit`

## Requirements
- R1: In byte mode, result bits [8i+7:8i] for i = 0..3 equal (A[8i+7:8i] - B[8i+7:8i]) mod 256, and no borrow crosses from one lane into the next.
- R2: In halfword mode, result bits [31:16] and [15:0] each equal the matching 16-bit lane of A minus that lane of B, mod 65536, with no borrow between the two lanes.
- R3: A lane overflows when the exact signed difference lies outside -128..+127 (byte mode) or outside -32768..+32767 (halfword mode). On every executed instruction flag_v is set to the OR of all lane overflows, so it can be set or cleared.
- R4: flag_sv is set to 1 by an executed instruction that overflows and otherwise keeps its value. It is cleared only by reset.
- R5: The operation never alters carry. flag_c registers carry_in on each accepted instruction word, and the result does not depend on carry_in.
- R6: An instruction executes only when bits [7:0] equal 0x0B and bits [27:20] equal 0x48 (byte mode) or 0x68 (halfword mode). Bits [19:16] are ignored. For any other word, out_wen is 0, out_result is 0, and flag_v and flag_sv keep their values.
- R7: out_dst carries bits [31:28] of the accepted word. src_a_idx shows bits [11:8] and src_b_idx shows bits [15:12] combinationally, in the same cycle.
- R8: out_valid is 1 in the cycle after each cycle in which in_valid was 1, and 0 otherwise. out_wen is never 1 unless out_valid is 1.
- R9: A synchronous active-high reset clears out_valid, out_wen, flag_v, flag_sv and flag_c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | First operand (minuend) |
| opnd_b | input | 32 | Second operand (subtrahend) |
| carry_in | input | 1 | Current carry status bit |
| src_a_idx | output | 4 | Decoded first source register index |
| src_b_idx | output | 4 | Decoded second source register index |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_wen | output | 1 | Register file write enable |
| out_dst | output | 4 | Destination register index |
| out_result | output | 32 | Packed difference |
| flag_v | output | 1 | Overflow status |
| flag_sv | output | 1 | Sticky overflow status |
| flag_c | output | 1 | Carry status, passed through unchanged |

## Verification
A wrong lane split or a borrow that leaks between lanes appears in out_result in the cycle just after the strobe. Values that cross a lane boundary, such as 0x80 minus 0x01 and 0x7FFF minus 0xFFFF, expose it at once. A wrong overflow rule shows on flag_v in that same cycle. A sticky bit that is lost or that is set wrongly persists, so any later observation of flag_sv reveals it until the next reset. A decode fault shows as out_wen rising for an invalid word, or as a flag that moves without an executed instruction, again one cycle after the input.

// File: rtl/psub_pkg.sv
package psub_pkg;
  localparam int RIDX_W = 4;

  localparam logic [7:0] OPC_PRIMARY  = 8'h0B;
  localparam logic [7:0] OPC_SUB_BYTE = 8'h48;
  localparam logic [7:0] OPC_SUB_HALF = 8'h68;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_BYTE = 2'd1,
    MODE_HALF = 2'd2
  } sub_mode_e;

  typedef struct packed {
    sub_mode_e           mode;
    logic [RIDX_W-1:0]   dst;
    logic [RIDX_W-1:0]   src_a;
    logic [RIDX_W-1:0]   src_b;
  } dec_t;
endpackage

// File: rtl/psub_decode.sv
module psub_decode
  import psub_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [7:0] primary;
  logic [7:0] secondary;

  assign primary   = instr[7:0];
  assign secondary = instr[27:20];

  always_comb begin
    dec.dst   = instr[31:28];
    dec.src_a = instr[11:8];
    dec.src_b = instr[15:12];
    dec.mode  = MODE_NONE;
    if (primary == OPC_PRIMARY) begin
      if (secondary == OPC_SUB_BYTE)      dec.mode = MODE_BYTE;
      else if (secondary == OPC_SUB_HALF) dec.mode = MODE_HALF;
    end
  end
endmodule

// File: rtl/psub_lane.sv
module psub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff,
  output logic         ovf
);
  logic [W:0] wide;

  // one guard bit: the two top bits disagree exactly when the signed result leaves range
  assign wide = {a[W-1], a} - {b[W-1], b};
  assign diff = wide[W-1:0];
  assign ovf  = wide[W] ^ wide[W-1];
endmodule

// File: rtl/psub_lane_array.sv
module psub_lane_array #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0]          a,
  input  logic [XLEN-1:0]          b,
  output logic [XLEN-1:0]          diff,
  output logic [XLEN/LANE_W-1:0]   ovf
);
  localparam int NLANES = XLEN / LANE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    psub_lane #(.W(LANE_W)) u_lane (
      .a    (a[i*LANE_W +: LANE_W]),
      .b    (b[i*LANE_W +: LANE_W]),
      .diff (diff[i*LANE_W +: LANE_W]),
      .ovf  (ovf[i])
    );
  end
endmodule

// File: rtl/psub_unit.sv
module psub_unit
  import psub_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic              carry_in,
  output logic [RIDX_W-1:0] src_a_idx,
  output logic [RIDX_W-1:0] src_b_idx,
  output logic              out_valid,
  output logic              out_wen,
  output logic [RIDX_W-1:0] out_dst,
  output logic [XLEN-1:0]   out_result,
  output logic              flag_v,
  output logic              flag_sv,
  output logic              flag_c
);
  localparam int NBYTE = XLEN / BYTE_W;
  localparam int NHALF = XLEN / HALF_W;

  dec_t             dec;
  logic [XLEN-1:0]  diff_b, diff_h, diff_sel;
  logic [NBYTE-1:0] ovf_b;
  logic [NHALF-1:0] ovf_h;
  logic             exec, ovf_any;

  psub_decode #(.XLEN(XLEN)) u_dec (.instr(instr), .dec(dec));

  psub_lane_array #(.XLEN(XLEN), .LANE_W(BYTE_W)) u_bytes (
    .a(opnd_a), .b(opnd_b), .diff(diff_b), .ovf(ovf_b)
  );

  psub_lane_array #(.XLEN(XLEN), .LANE_W(HALF_W)) u_halves (
    .a(opnd_a), .b(opnd_b), .diff(diff_h), .ovf(ovf_h)
  );

  assign src_a_idx = dec.src_a;
  assign src_b_idx = dec.src_b;

  always_comb begin
    exec     = 1'b0;
    diff_sel = '0;
    ovf_any  = 1'b0;
    case (dec.mode)
      MODE_BYTE: begin
        exec     = 1'b1;
        diff_sel = diff_b;
        ovf_any  = |ovf_b;
      end
      MODE_HALF: begin
        exec     = 1'b1;
        diff_sel = diff_h;
        ovf_any  = |ovf_h;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wen    <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
      flag_v     <= 1'b0;
      flag_sv    <= 1'b0;
      flag_c     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wen   <= in_valid & exec;
      if (in_valid) begin
        out_dst    <= dec.dst;
        out_result <= diff_sel;
        flag_c     <= carry_in;
        if (exec) begin
          flag_v <= ovf_any;
          if (ovf_any) flag_sv <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psub_unit_sva.sv
module psub_unit_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] instr,
  input logic            carry_in,
  input logic            out_valid,
  input logic            out_wen,
  input logic            flag_v,
  input logic            flag_sv,
  input logic            flag_c
);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_wen_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_valid);

  assert_sticky_covers_v_R4: assert property (@(posedge clk) disable iff (rst)
    (out_wen && flag_v) |-> flag_sv);

  assert_sticky_never_drops_R4: assert property (@(posedge clk) disable iff (rst)
    !$fell(flag_sv));

  assert_flags_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !out_wen |-> ($stable(flag_v) && $stable(flag_sv)));

  assert_wen_primary_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[7:0] != 8'h0B) |=> !out_wen);

  assert_carry_pass_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_c == $past(carry_in)));
endmodule

bind psub_unit psub_unit_sva #(.XLEN(XLEN)) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .carry_in(carry_in),
  .out_valid(out_valid), .out_wen(out_wen), .flag_v(flag_v), .flag_sv(flag_sv),
  .flag_c(flag_c)
);

// File: tb/psub_unit_tb.sv
`timescale 1ns/1ps
module psub_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, opnd_a, opnd_b;
  logic        carry_in;
  logic [3:0]  src_a_idx, src_b_idx, out_dst;
  logic        out_valid, out_wen, flag_v, flag_sv, flag_c;
  logic [31:0] out_result;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic m_v, m_sv;

  always #5 clk = ~clk;

  psub_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .carry_in(carry_in), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .out_valid(out_valid), .out_wen(out_wen), .out_dst(out_dst), .out_result(out_result),
    .flag_v(flag_v), .flag_sv(flag_sv), .flag_c(flag_c)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] sec, input logic [3:0] c, input logic [3:0] a,
                                     input logic [3:0] b, input logic [3:0] junk);
    return {c, sec, junk, b, a, 8'h0B};
  endfunction

  // independent reference using integer arithmetic
  task automatic ref_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic ok, output logic ov);
    int d;
    r  = '0;
    ov = 1'b0;
    ok = (ins[7:0] == 8'h0B) && (ins[27:20] == 8'h48 || ins[27:20] == 8'h68);
    if (ok && ins[27:20] == 8'h48) begin
      for (int i = 0; i < 4; i++) begin
        d = int'($signed(a[8*i +: 8])) - int'($signed(b[8*i +: 8]));
        r[8*i +: 8] = d[7:0];
        if (d > 127 || d < -128) ov = 1'b1;
      end
    end else if (ok) begin
      for (int i = 0; i < 2; i++) begin
        d = int'($signed(a[16*i +: 16])) - int'($signed(b[16*i +: 16]));
        r[16*i +: 16] = d[15:0];
        if (d > 32767 || d < -32768) ov = 1'b1;
      end
    end
  endtask

  task automatic do_op(input string req, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic cin);
    logic [31:0] r;
    logic ok, ov;
    ref_op(ins, a, b, r, ok, ov);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; opnd_a = a; opnd_b = b; carry_in = cin;
    #1;
    chk("R7", "src_a_idx", 32'(src_a_idx), 32'(ins[11:8]));
    chk("R7", "src_b_idx", 32'(src_b_idx), 32'(ins[15:12]));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (ok) begin
      m_v = ov;
      if (ov) m_sv = 1'b1;
    end
    chk("R8", "out_valid", 32'(out_valid), 32'd1);
    chk(req, "out_wen", 32'(out_wen), 32'(ok));
    chk(req, "out_result", out_result, r);
    chk("R7", "out_dst", 32'(out_dst), 32'(ins[31:28]));
    chk("R3", "flag_v", 32'(flag_v), 32'(m_v));
    chk("R4", "flag_sv", 32'(flag_sv), 32'(m_sv));
    chk("R5", "flag_c", 32'(flag_c), 32'(cin));
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0; carry_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_v = 1'b0; m_sv = 1'b0;
    chk("R9", "out_valid", 32'(out_valid), 32'd0);
    chk("R9", "out_wen", 32'(out_wen), 32'd0);
    chk("R9", "flag_v", 32'(flag_v), 32'd0);
    chk("R9", "flag_sv", 32'(flag_sv), 32'd0);
    chk("R9", "flag_c", 32'(flag_c), 32'd0);
  endtask

  task automatic test_byte_lanes();   // R1
    do_op("R1", mk(8'h48, 4'd3, 4'd1, 4'd2, 4'd0), 32'h0000_0080, 32'h0000_0001, 1'b0);
    do_op("R1", mk(8'h48, 4'd4, 4'd5, 4'd6, 4'd0), 32'h0000_0000, 32'h0000_0001, 1'b1);
    do_op("R1", mk(8'h48, 4'd9, 4'd7, 4'd8, 4'd0), 32'h1234_5678, 32'h0102_0304, 1'b0);
  endtask

  task automatic test_half_lanes();   // R2
    do_op("R2", mk(8'h68, 4'd1, 4'd2, 4'd3, 4'd0), 32'h0000_7FFF, 32'h0000_FFFF, 1'b1);
    do_op("R2", mk(8'h68, 4'd15, 4'd0, 4'd14, 4'd0), 32'h0000_0000, 32'h0000_0001, 1'b0);
    do_op("R2", mk(8'h68, 4'd2, 4'd3, 4'd4, 4'd0), 32'h8000_1234, 32'h0001_0034, 1'b0);
  endtask

  task automatic test_overflow_clear();   // R3 V clears, R4 SV holds
    do_op("R3", mk(8'h48, 4'd1, 4'd1, 4'd1, 4'd0), 32'h7F00_0000, 32'hFF00_0000, 1'b0);
    do_op("R3", mk(8'h48, 4'd1, 4'd1, 4'd1, 4'd0), 32'h0505_0505, 32'h0101_0101, 1'b0);
    chk("R4", "sv held after clean op", 32'(flag_sv), 32'd1);
  endtask

  task automatic test_invalid();   // R6
    do_op("R6", mk(8'h48, 4'd2, 4'd1, 4'd1, 4'd0) ^ 32'h0000_0001, 32'h8000_0000, 32'h0100_0000, 1'b1);
    do_op("R6", mk(8'h49, 4'd2, 4'd1, 4'd1, 4'd0), 32'h8000_0000, 32'h0100_0000, 1'b0);
    do_op("R6", mk(8'h68, 4'd6, 4'd1, 4'd1, 4'hF), 32'h0003_0002, 32'h0001_0001, 1'b0);
  endtask

  task automatic test_idle();   // R8
    repeat (3) @(negedge clk);
    chk("R8", "idle out_valid", 32'(out_valid), 32'd0);
    chk("R8", "idle out_wen", 32'(out_wen), 32'd0);
  endtask

  task automatic test_random();   // R1 R2 R3 R4
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a, b;
      logic [7:0] sec;
      a = $urandom; b = $urandom;
      sec = n[0] ? 8'h68 : 8'h48;
      do_op(n[0] ? "R2" : "R1", mk(sec, 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom)), a, b, 1'($urandom));
    end
  endtask

  task automatic test_reset_clears();   // R9
    do_op("R3", mk(8'h48, 4'd1, 4'd1, 4'd1, 4'd0), 32'h0000_0080, 32'h0000_0001, 1'b1);
    do_reset();
  endtask

  initial begin
    do_reset();
    test_byte_lanes();
    test_half_lanes();
    test_overflow_clear();
    test_invalid();
    test_idle();
    test_reset_clears();
    test_random();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule